// File: doc/BRIEF.md
# Dual-Mode Colour Palette Memory

This block holds the colour palette of a small tile-and-sprite video processor. It has 128 colour entries. Each entry is split across two byte planes of a 256-byte store. Entry `n` keeps its low byte at byte address `n` and its high byte at byte address `n + 128`. A processor writes and reads single bytes through a byte-address port. The pixel pipeline looks up an entry by a 7-bit colour number.

A static strap picks how an entry is read out. In direct-colour mode, the two bytes form a 15-bit RGB value, and the block widens it to 24-bit RGB. In indexed mode, the default, the block returns a 6-bit index into an external master colour table. The lookup is registered, and a valid flag follows each request. Reset clears every palette byte.

Top module: `palram`

## Requirements
- R1: After reset every byte of the store reads back as 0x00 on `cpu_rdata`, and `px_valid` is low.
- R2: `cpu_rdata` always shows the full 8-bit byte stored at `cpu_addr`, in either mode. A byte written with `cpu_we` at a clock edge reads back after that edge.
- R3: Entry `n` (0..127) takes its low byte from address `n` and its high byte from address `n + 128`. Address bit 7 selects the plane.
- R4: With `rgb_mode` = 1 the word is {high, low}. Blue comes from bits 4:0, green from bits 9:5 and red from bits 14:10; bit 15 is ignored. Each 5-bit component is shifted left by three with zero fill. `px_rgb` is {red[23:16], green[15:8], blue[7:0]} and `px_index` is 0.
- R5: With `rgb_mode` = 0, `px_index` equals bits 5:0 of the low byte. The high byte and bits 7:6 of the low byte have no effect, and `px_rgb` is 0.
- R6: `px_valid` is high in exactly the cycle after a cycle with `px_req` high. The colour outputs for that request are presented in the same cycle as `px_valid`.
- R7: A write and a lookup in the same cycle are both served. The lookup returns the entry's contents from before the write, and the write is stored.
- R8: In a cycle after a cycle without `px_req`, `px_rgb` and `px_index` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rgb_mode | input | 1 | Static strap: 1 = direct RGB, 0 = indexed |
| cpu_we | input | 1 | Byte write strobe |
| cpu_addr | input | 8 | Byte address; bit 7 selects the high plane |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Byte stored at `cpu_addr` |
| px_req | input | 1 | Lookup request |
| px_idx | input | 7 | Colour entry number |
| px_valid | output | 1 | Lookup result valid |
| px_rgb | output | 24 | Widened RGB result (direct mode) |
| px_index | output | 6 | Master-table index (indexed mode) |

## Verification
The bench aims at the places where a decoder can slip by one bit.

- **Plane crossing (R3):** a swapped or misaligned plane shows up as wrong colours for entries 0 and 127.
- **Green field (R4):** green straddles both bytes. An off-by-one field split gives a wrong green, with blue or red bits leaking into it.
- **Ignored bits (R4, R5):** bit 15 and the ignored bits of indexed mode are set to all ones. A decoder that uses them produces values out of range.
- **Simultaneous write and lookup (R7):** a lookup that sees write-through data returns the new colour instead of the old one.
- **Idle cycles (R8):** a result register that is not held changes its colour outputs during idle cycles.

// File: rtl/palram.sv
module palram #(
  parameter int ENTRIES = 128,
  parameter int LW      = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rgb_mode,
  input  logic                       cpu_we,
  input  logic [$clog2(ENTRIES):0]   cpu_addr,
  input  logic [7:0]                 cpu_wdata,
  output logic [7:0]                 cpu_rdata,
  input  logic                       px_req,
  input  logic [$clog2(ENTRIES)-1:0] px_idx,
  output logic                       px_valid,
  output logic [23:0]                px_rgb,
  output logic [LW-1:0]              px_index
);
  localparam int IW    = $clog2(ENTRIES);
  localparam int DEPTH = 2 * ENTRIES;

  logic [7:0] mem [DEPTH];
  logic [23:0] rgb_d;
  logic [LW-1:0] idx_d;

  assign cpu_rdata = mem[cpu_addr];

  assign rgb_d = rgb_mode ?
    {mem[{1'b1, px_idx}][6:2], 3'b000,
     mem[{1'b1, px_idx}][1:0], mem[{1'b0, px_idx}][7:5], 3'b000,
     mem[{1'b0, px_idx}][4:0], 3'b000} : 24'd0;

  assign idx_d = rgb_mode ? '0 : mem[{1'b0, px_idx}][LW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (cpu_we) begin
      mem[cpu_addr] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_valid <= 1'b0;
      px_rgb   <= '0;
      px_index <= '0;
    end else begin
      px_valid <= px_req;
      if (px_req) begin
        px_rgb   <= rgb_d;
        px_index <= idx_d;
      end
    end
  end

  initial begin
    assert (IW >= 1 && LW <= 8);
  end
endmodule

// File: rtl/palram_chk.sv
module palram_chk #(
  parameter int AW = 8,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rgb_mode,
  input logic          cpu_we,
  input logic [AW-1:0] cpu_addr,
  input logic [7:0]    cpu_wdata,
  input logic [7:0]    cpu_rdata,
  input logic          px_req,
  input logic          px_valid,
  input logic [23:0]   px_rgb,
  input logic [LW-1:0] px_index
);
  // R6
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_req |=> px_valid);

  // R6
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !px_req |=> !px_valid);

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> (cpu_addr != $past(cpu_addr)) || (cpu_rdata == $past(cpu_wdata)));

  // R4
  rgb_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && rgb_mode) |->
      (px_rgb[2:0] == 3'b0 && px_rgb[10:8] == 3'b0 && px_rgb[18:16] == 3'b0 && px_index == '0));

  // R5
  legacy_no_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !rgb_mode) |-> px_rgb == 24'd0);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !px_req |=> ($stable(px_rgb) && $stable(px_index)));
endmodule

bind palram palram_chk #(.AW($clog2(ENTRIES) + 1), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rgb_mode(rgb_mode), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .px_req(px_req), .px_valid(px_valid), .px_rgb(px_rgb), .px_index(px_index)
);

// File: tb/palram_tb.sv
`timescale 1ns/1ps
module palram_tb;
  logic clk = 1'b0;
  logic rst_n, rgb_mode, cpu_we, px_req;
  logic [7:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [6:0] px_idx;
  logic px_valid;
  logic [23:0] px_rgb;
  logic [5:0] px_index;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [256];
  logic [23:0] last_rgb;
  logic [5:0] last_idx;

  always #4 clk = ~clk;

  palram u_dut (
    .clk(clk), .rst_n(rst_n), .rgb_mode(rgb_mode), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .px_req(px_req), .px_idx(px_idx), .px_valid(px_valid),
    .px_rgb(px_rgb), .px_index(px_index)
  );

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired (act=running exp=done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [23:0] f_rgb(logic [7:0] lo, logic [7:0] hi, logic m);
    logic [15:0] w;
    w = {hi, lo};
    if (!m) return 24'd0;
    return {w[14:10], 3'b0, w[9:5], 3'b0, w[4:0], 3'b0};
  endfunction

  function automatic logic [5:0] f_idx(logic [7:0] lo, logic [7:0] hi, logic m);
    logic [11:0] v;
    v = {hi[5:0], lo[5:0]};
    return m ? 6'd0 : v[5:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d,
                      input bit rq, input logic [6:0] ix, input string tag);
    logic [23:0] er;
    logic [5:0] ei;
    cpu_we = we; cpu_addr = a; cpu_wdata = d; px_req = rq; px_idx = ix;
    er = rq ? f_rgb(model[{1'b0, ix}], model[{1'b1, ix}], rgb_mode) : last_rgb;
    ei = rq ? f_idx(model[{1'b0, ix}], model[{1'b1, ix}], rgb_mode) : last_idx;
    @(posedge clk);
    if (we) model[a] = d;
    @(negedge clk);
    chk(px_valid == rq, "R6 valid", 32'(px_valid), 32'(rq));
    chk(px_rgb == er, tag, 32'(px_rgb), 32'(er));
    chk(px_index == ei, tag, 32'(px_index), 32'(ei));
    chk(cpu_rdata == model[a], "R2 readback", 32'(cpu_rdata), 32'(model[a]));
    last_rgb = er; last_idx = ei;
    cpu_we = 1'b0; px_req = 1'b0;
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; rgb_mode = m;
    cpu_we = 1'b0; px_req = 1'b0; cpu_addr = '0; cpu_wdata = '0; px_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    last_rgb = '0; last_idx = '0;
    chk(px_valid == 1'b0, "R1 valid after reset", 32'(px_valid), 0);
    for (int i = 0; i < 256; i++) begin
      cpu_addr = 8'(i); #1;
      chk(cpu_rdata == 8'h00, "R1 cleared byte", 32'(cpu_rdata), 0);
    end
    @(negedge clk);
  endtask

  task automatic random_run(input int n);
    for (int k = 0; k < n; k++) begin
      bit we, rq;
      logic [7:0] a, d;
      logic [6:0] ix;
      we = ($urandom % 2) == 1;
      rq = ($urandom % 4) != 0;
      ix = 7'($urandom);
      a = ($urandom % 3 == 0) ? {1'($urandom), ix} : 8'($urandom);
      d = 8'($urandom);
      step(we, a, d, rq, ix, rgb_mode ? "R4 R7 random rgb" : "R5 R7 random indexed");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // indexed mode
    do_reset(1'b0);
    step(1'b1, 8'h85, 8'hFF, 1'b0, 7'd0, "R8 idle");
    step(1'b1, 8'h05, 8'hC5, 1'b1, 7'd5, "R7 old data on same-cycle write");
    step(1'b0, 8'h05, 8'h00, 1'b1, 7'd5, "R5 high byte and bits 7:6 ignored");
    chk(px_index == 6'h05, "R5 index value", 32'(px_index), 32'h05);
    step(1'b0, 8'h00, 8'h00, 1'b0, 7'd9, "R8 hold when idle");
    random_run(1500);

    // direct RGB mode
    do_reset(1'b1);
    step(1'b1, 8'h7F, 8'hFF, 1'b0, 7'd0, "R3 low plane write");
    step(1'b1, 8'hFF, 8'h7F, 1'b0, 7'd0, "R3 high plane write");
    step(1'b0, 8'h00, 8'h00, 1'b1, 7'd127, "R4 full white");
    chk(px_rgb == 24'hF8F8F8, "R4 white value", 32'(px_rgb), 32'hF8F8F8);
    step(1'b1, 8'h80, 8'hFC, 1'b0, 7'd0, "R3 entry0 high");
    step(1'b0, 8'h00, 8'h00, 1'b1, 7'd0, "R4 red only, bit15 ignored");
    chk(px_rgb == 24'hF80000, "R4 red value", 32'(px_rgb), 32'hF80000);
    step(1'b1, 8'h80, 8'h03, 1'b0, 7'd0, "R8 idle");
    step(1'b1, 8'h00, 8'hE0, 1'b1, 7'd0, "R7 old data on same-cycle write");
    step(1'b0, 8'h00, 8'h00, 1'b1, 7'd0, "R4 green straddles planes");
    chk(px_rgb == 24'h00F800, "R4 green value", 32'(px_rgb), 32'h00F800);
    step(1'b0, 8'h80, 8'h00, 1'b0, 7'd3, "R8 hold when idle");
    chk(cpu_rdata == 8'h03, "R2 full byte readback", 32'(cpu_rdata), 32'h03);
    random_run(1500);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule